// File: doc/BRIEF.md
# Region-Tagged Translation Purge Unit

This block keeps a small fully associative translation cache and, beside it, a smaller file of pinned translation registers. Every entry carries a region identifier, a virtual page address and a page size given as a log2 code. A write port loads entries. Purge commands invalidate entries whose page range overlaps the range named in the command. Each command takes one clock cycle, and `done` pulses for one cycle after the command is taken.

The purge compares only virtual address bits 60..0 together with the region identifier. The three region-number bits at the top of the address take no part in the match. Two pages overlap when their addresses are equal after both are aligned down to the larger of the two page sizes. A partial overlap therefore removes an entry of any size. A cache purge is unsafe when it would hit a valid pinned entry. In that case the block raises `abort` and leaves the cache untouched. A size code outside the supported set never does nothing: a cache purge with such a code over-purges the whole cache, and a pinned purge with such a code clears every pinned entry.

A separate flush command empties the whole cache. The valid bits of both stores are brought out on ports so that the effect of every command can be observed.

Top module: `tlb_purge_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, every cache and pinned valid bit reads 0 and `done` and `abort` are 0.
- R2: With `wr_en`=1 and `cmd_valid`=0 at a rising edge, the entry selected by `wr_idx` becomes valid from the next cycle. `wr_pin`=0 selects the cache, and `wr_pin`=1 selects a pinned register using only the low `$clog2(TR_N)` bits of `wr_idx`. A write presented while `cmd_valid`=1 is ignored.
- R3: A cache purge (`cmd_op`=2'b00) with a supported size clears every valid cache entry whose region equals `cmd_rid` and whose range overlaps. Overlap means that bits 60..0 of both addresses agree above the larger of the two size codes. All other cache entries keep their valid bits.
- R4: Address bits 63..61 have no effect on any purge match.
- R5: Size codes 12 to 28 inclusive (4 KiB to 256 MiB) are supported. A cache purge with any other code clears every cache entry and raises no abort.
- R6: A cache purge with a supported size that overlaps a valid pinned entry of the same region raises `abort` for one cycle, together with `done`. The cache valid bits stay unchanged for that command.
- R7: A pinned purge (`cmd_op`=2'b01) clears every overlapping valid pinned entry, using the same rules as R3 and R4. With an unsupported size it clears all pinned entries. It never raises `abort` and never changes the cache.
- R8: A flush (`cmd_op`=2'b10) clears every cache entry, leaves the pinned entries unchanged and raises no abort.
- R9: `done` is 1 in the cycle after each accepted command with `cmd_op` 2'b00, 2'b01 or 2'b10, and 0 otherwise. `cmd_op`=2'b11 changes no state and gives no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load an entry |
| wr_pin | input | 1 | 1 selects the pinned file, 0 selects the cache |
| wr_idx | input | WI_W (4) | Entry slot to load |
| wr_rid | input | RID_W (24) | Region identifier of the new entry |
| wr_va | input | 64 | Virtual page address of the new entry |
| wr_size | input | 5 | log2 page size of the new entry |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 cache purge, 01 pinned purge, 10 flush, 11 none |
| cmd_rid | input | RID_W (24) | Purge region identifier |
| cmd_va | input | 64 | Purge virtual address |
| cmd_size | input | 5 | log2 purge size |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | Unsafe-purge abort pulse |
| tc_valid | output | TC_N (16) | Cache valid bits |
| tr_valid | output | TR_N (8) | Pinned valid bits |

## Verification
Directed cases separate the overlap forms. They cover a large entry hit by a small purge, a small entry swallowed by a large purge, an entry in the same place under another region (kept), and an adjacent page (kept). A purge that differs only in bits 63..61 must still hit, which shows whether those bits are ignored. Size codes just outside the supported range (11 and 29) must flush the cache without an abort, which tells over-purge apart from both a silent drop and a false abort. Random traffic mixes writes, all four opcodes, three regions and size codes from 10 to 30 inside a narrow address window, so that overlaps, collisions with pinned entries and unsupported sizes occur often. Every output is compared against a bench model after each step.

// File: rtl/tlb_purge_pkg.sv
package tlb_purge_pkg;
  localparam int VA_W    = 64;
  localparam int MATCH_W = 61;
  localparam int SZ_W    = 5;
  localparam int MIN_SZ  = 12;
  localparam int MAX_SZ  = 28;

  typedef enum logic [1:0] {
    OP_PURGE_TC = 2'b00,
    OP_PURGE_TR = 2'b01,
    OP_FLUSH_TC = 2'b10,
    OP_NONE     = 2'b11
  } purge_op_e;
endpackage

// File: rtl/tpu_overlap.sv
module tpu_overlap #(
  parameter int RID_W = 24,
  parameter int MW    = 61,
  parameter int SZ_W  = 5
) (
  input  logic [RID_W-1:0] e_rid,
  input  logic [MW-1:0]    e_va,
  input  logic [SZ_W-1:0]  e_size,
  input  logic [RID_W-1:0] p_rid,
  input  logic [MW-1:0]    p_va,
  input  logic [SZ_W-1:0]  p_size,
  output logic             hit
);
  logic [SZ_W-1:0] big;
  logic [MW-1:0]   keep;

  always_comb begin
    big  = (e_size > p_size) ? e_size : p_size;
    keep = ~((MW'(1) << big) - MW'(1));
    hit  = (e_rid == p_rid) && (((e_va ^ p_va) & keep) == '0);
  end
endmodule

// File: rtl/tpu_bank.sv
module tpu_bank #(
  parameter int N     = 16,
  parameter int RID_W = 24,
  parameter int MW    = 61,
  parameter int SZ_W  = 5,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RID_W-1:0] wr_rid,
  input  logic [MW-1:0]    wr_va,
  input  logic [SZ_W-1:0]  wr_size,
  input  logic [RID_W-1:0] q_rid,
  input  logic [MW-1:0]    q_va,
  input  logic [SZ_W-1:0]  q_size,
  input  logic [N-1:0]     clr,
  output logic [N-1:0]     hit,
  output logic [N-1:0]     valid
);
  logic [RID_W-1:0] rid_q  [N];
  logic [MW-1:0]    va_q   [N];
  logic [SZ_W-1:0]  size_q [N];
  logic [N-1:0]     valid_q, valid_d;
  logic [N-1:0]     ovl;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(gi));

      always_ff @(posedge clk) begin
        if (sel) begin
          rid_q[gi]  <= wr_rid;
          va_q[gi]   <= wr_va;
          size_q[gi] <= wr_size;
        end
      end

      tpu_overlap #(.RID_W(RID_W), .MW(MW), .SZ_W(SZ_W)) u_ovl (
        .e_rid (rid_q[gi]),
        .e_va  (va_q[gi]),
        .e_size(size_q[gi]),
        .p_rid (q_rid),
        .p_va  (q_va),
        .p_size(q_size),
        .hit   (ovl[gi])
      );
    end
  endgenerate

  always_comb begin
    valid_d = valid_q & ~clr;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign hit   = valid_q & ovl;
  assign valid = valid_q;

  // R2: a valid bit only ever comes up through the write port
  assert_no_spurious_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((valid_q & ~$past(valid_q)) == '0));
endmodule

// File: rtl/tlb_purge_unit.sv
module tlb_purge_unit
  import tlb_purge_pkg::*;
#(
  parameter int RID_W = 24,
  parameter int TC_N  = 16,
  parameter int TR_N  = 8,
  localparam int TC_IDX_W = (TC_N > 1) ? $clog2(TC_N) : 1,
  localparam int TR_IDX_W = (TR_N > 1) ? $clog2(TR_N) : 1,
  localparam int WI_W     = (TC_IDX_W > TR_IDX_W) ? TC_IDX_W : TR_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_pin,
  input  logic [WI_W-1:0]  wr_idx,
  input  logic [RID_W-1:0] wr_rid,
  input  logic [VA_W-1:0]  wr_va,
  input  logic [SZ_W-1:0]  wr_size,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [RID_W-1:0] cmd_rid,
  input  logic [VA_W-1:0]  cmd_va,
  input  logic [SZ_W-1:0]  cmd_size,
  output logic             done,
  output logic             abort,
  output logic [TC_N-1:0]  tc_valid,
  output logic [TR_N-1:0]  tr_valid
);
  purge_op_e     op;
  logic          wr_go, tc_wr, tr_wr, size_ok, pin_clash;
  logic [TC_N-1:0] tc_hit, tc_clr;
  logic [TR_N-1:0] tr_hit, tr_clr;
  logic          done_d, abort_d, done_q, abort_q;

  assign op    = purge_op_e'(cmd_op);
  assign wr_go = wr_en && !cmd_valid;
  assign tc_wr = wr_go && !wr_pin;
  assign tr_wr = wr_go && wr_pin;

  tpu_bank #(.N(TC_N), .RID_W(RID_W), .MW(MATCH_W), .SZ_W(SZ_W)) u_tc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tc_wr),
    .wr_idx (wr_idx[TC_IDX_W-1:0]),
    .wr_rid (wr_rid),
    .wr_va  (wr_va[MATCH_W-1:0]),
    .wr_size(wr_size),
    .q_rid  (cmd_rid),
    .q_va   (cmd_va[MATCH_W-1:0]),
    .q_size (cmd_size),
    .clr    (tc_clr),
    .hit    (tc_hit),
    .valid  (tc_valid)
  );

  tpu_bank #(.N(TR_N), .RID_W(RID_W), .MW(MATCH_W), .SZ_W(SZ_W)) u_tr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tr_wr),
    .wr_idx (wr_idx[TR_IDX_W-1:0]),
    .wr_rid (wr_rid),
    .wr_va  (wr_va[MATCH_W-1:0]),
    .wr_size(wr_size),
    .q_rid  (cmd_rid),
    .q_va   (cmd_va[MATCH_W-1:0]),
    .q_size (cmd_size),
    .clr    (tr_clr),
    .hit    (tr_hit),
    .valid  (tr_valid)
  );

  always_comb begin
    size_ok   = (cmd_size >= SZ_W'(MIN_SZ)) && (cmd_size <= SZ_W'(MAX_SZ));
    pin_clash = |tr_hit;
    tc_clr    = '0;
    tr_clr    = '0;
    done_d    = 1'b0;
    abort_d   = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_PURGE_TC: begin
          done_d = 1'b1;
          if (!size_ok)       tc_clr  = '1;
          else if (pin_clash) abort_d = 1'b1;
          else                tc_clr  = tc_hit;
        end
        OP_PURGE_TR: begin
          done_d = 1'b1;
          tr_clr = size_ok ? tr_hit : '1;
        end
        OP_FLUSH_TC: begin
          done_d = 1'b1;
          tc_clr = '1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      abort_q <= abort_d;
    end
  end

  assign done  = done_q;
  assign abort = abort_q;

  // R6: an abort leaves the cache exactly as it was
  assert_abort_keeps_cache_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (tc_valid == $past(tc_valid)));
  // R6: abort is reported only with completion
  assert_abort_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> done);
  // R8: flush empties the cache
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10) |=> (tc_valid == '0 && !abort));
  // R7: pinned purge never aborts and never touches the cache
  assert_pin_purge_safe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01) |=> (!abort && tc_valid == $past(tc_valid)));
  // R9: no command, no completion
  assert_idle_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_op == 2'b11) |=> !done);
endmodule

// File: tb/tlb_purge_unit_test.sv
`timescale 1ns/1ps
module tlb_purge_unit_test;
  localparam int RID_W = 24;
  localparam int TC_N  = 16;
  localparam int TR_N  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_pin;
  logic [3:0] wr_idx;
  logic [RID_W-1:0] wr_rid, cmd_rid;
  logic [63:0] wr_va, cmd_va;
  logic [4:0] wr_size, cmd_size;
  logic cmd_valid;
  logic [1:0] cmd_op;
  logic done, abort;
  logic [TC_N-1:0] tc_valid;
  logic [TR_N-1:0] tr_valid;

  int n_cmp = 0;
  int n_bad = 0;

  tlb_purge_unit #(.RID_W(RID_W), .TC_N(TC_N), .TR_N(TR_N)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pin(wr_pin), .wr_idx(wr_idx),
    .wr_rid(wr_rid), .wr_va(wr_va), .wr_size(wr_size), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_rid(cmd_rid), .cmd_va(cmd_va), .cmd_size(cmd_size),
    .done(done), .abort(abort), .tc_valid(tc_valid), .tr_valid(tr_valid)
  );

  always #10 clk = ~clk;

  // bench model
  logic [RID_W-1:0] m_tc_rid [TC_N];
  logic [60:0]      m_tc_va  [TC_N];
  int               m_tc_sz  [TC_N];
  logic [TC_N-1:0]  m_tc_v;
  logic [RID_W-1:0] m_tr_rid [TR_N];
  logic [60:0]      m_tr_va  [TR_N];
  int               m_tr_sz  [TR_N];
  logic [TR_N-1:0]  m_tr_v;

  function automatic bit ovl(logic [RID_W-1:0] ra, logic [63:0] va, int sa,
                             logic [RID_W-1:0] rb, logic [63:0] vb, int sb);
    int big = (sa > sb) ? sa : sb;
    logic [60:0] a = va[60:0] >> big;
    logic [60:0] b = vb[60:0] >> big;
    return (ra == rb) && (a == b);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(tc_valid == m_tc_v, {req, " cache valid"}, 64'(tc_valid), 64'(m_tc_v));
    chk(tr_valid == m_tr_v, {req, " pinned valid"}, 64'(tr_valid), 64'(m_tr_v));
  endtask

  task automatic write_entry(bit pin, int idx, logic [RID_W-1:0] rid, logic [63:0] va,
                             int sz, string req);
    @(negedge clk);
    wr_en = 1'b1; wr_pin = pin; wr_idx = 4'(idx); wr_rid = rid; wr_va = va; wr_size = 5'(sz);
    @(negedge clk);
    wr_en = 1'b0;
    if (pin) begin
      m_tr_rid[idx % TR_N] = rid; m_tr_va[idx % TR_N] = va[60:0];
      m_tr_sz[idx % TR_N] = sz;   m_tr_v[idx % TR_N] = 1'b1;
    end else begin
      m_tc_rid[idx] = rid; m_tc_va[idx] = va[60:0]; m_tc_sz[idx] = sz; m_tc_v[idx] = 1'b1;
    end
    check_state(req);
  endtask

  task automatic run_cmd(int op, logic [RID_W-1:0] rid, logic [63:0] va, int sz, string req);
    bit ok = (sz >= 12) && (sz <= 28);
    bit e_done = (op != 3);
    bit e_abort = 1'b0;
    bit clash = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_rid = rid; cmd_va = va; cmd_size = 5'(sz);
    @(negedge clk);
    cmd_valid = 1'b0;
    case (op)
      0: begin
        for (int i = 0; i < TR_N; i++)
          if (m_tr_v[i] && ovl(m_tr_rid[i], {3'b0, m_tr_va[i]}, m_tr_sz[i], rid, va, sz))
            clash = 1'b1;
        if (!ok) m_tc_v = '0;
        else if (clash) e_abort = 1'b1;
        else
          for (int i = 0; i < TC_N; i++)
            if (ovl(m_tc_rid[i], {3'b0, m_tc_va[i]}, m_tc_sz[i], rid, va, sz)) m_tc_v[i] = 1'b0;
      end
      1: begin
        if (!ok) m_tr_v = '0;
        else
          for (int i = 0; i < TR_N; i++)
            if (ovl(m_tr_rid[i], {3'b0, m_tr_va[i]}, m_tr_sz[i], rid, va, sz)) m_tr_v[i] = 1'b0;
      end
      2: m_tc_v = '0;
      default: ;
    endcase
    chk(done == e_done, {req, " done"}, 64'(done), 64'(e_done));
    chk(abort == e_abort, {req, " abort"}, 64'(abort), 64'(e_abort));
    check_state(req);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 1'b0; wr_pin = 1'b0; wr_idx = '0; wr_rid = '0; wr_va = '0;
    wr_size = 5'd12; cmd_valid = 1'b0; cmd_op = 2'b11; cmd_rid = '0; cmd_va = '0;
    cmd_size = 5'd12;
    m_tc_v = '0; m_tr_v = '0;
    for (int i = 0; i < TC_N; i++) begin m_tc_rid[i] = '0; m_tc_va[i] = '0; m_tc_sz[i] = 12; end
    for (int i = 0; i < TR_N; i++) begin m_tr_rid[i] = '0; m_tr_va[i] = '0; m_tr_sz[i] = 12; end
    repeat (3) @(negedge clk);
    chk(tc_valid == '0 && tr_valid == '0 && !done && !abort, "R1 in reset",
        {tc_valid, tr_valid, 6'b0, done, abort}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tc_valid == '0 && tr_valid == '0 && !done && !abort, "R1 after reset",
        {tc_valid, tr_valid, 6'b0, done, abort}, 64'h0);

    // R2 / R3 / R4: region bits at the top ignored
    write_entry(0, 0, 24'd5, 64'h0000_0000_1000_0000, 12, "R2 write cache");
    write_entry(0, 1, 24'd5, 64'h0000_0000_1000_1000, 12, "R2 write neighbour");
    write_entry(0, 2, 24'd6, 64'h0000_0000_1000_0000, 12, "R2 write other rid");
    run_cmd(0, 24'd5, 64'hE000_0000_1000_0000, 12, "R4 vrn ignored R3 exact");

    // R3: partial overlaps both ways
    write_entry(0, 3, 24'd5, 64'h0000_0000_4020_0000, 21, "R2 big entry");
    run_cmd(0, 24'd5, 64'h0000_0000_4030_5000, 12, "R3 small purge in big page");
    write_entry(0, 4, 24'd5, 64'h0000_0000_4030_7000, 12, "R2 small entry");
    write_entry(0, 5, 24'd5, 64'h0000_0000_4100_0000, 12, "R2 outside entry");
    run_cmd(0, 24'd5, 64'h0000_0000_4000_0000, 24, "R3 big purge over small page");

    // R5: unsupported sizes over-purge
    run_cmd(0, 24'd9, 64'h0, 29, "R5 size 29 flushes");
    write_entry(0, 7, 24'd1, 64'h0000_0000_0000_3000, 12, "R2 refill");
    run_cmd(0, 24'd9, 64'h0, 11, "R5 size 11 flushes");

    // R6: pinned collision
    write_entry(1, 9, 24'd7, 64'h0000_0000_8000_0000, 24, "R2 pinned low idx bits");
    write_entry(0, 8, 24'd7, 64'h0000_0000_8000_0000, 12, "R2 cache under pin");
    run_cmd(0, 24'd7, 64'h2000_0000_8000_2000, 12, "R6 clash aborts");
    run_cmd(0, 24'd8, 64'h0000_0000_8000_0000, 12, "R6 other rid no clash");

    // R7 / R8 / R9
    run_cmd(1, 24'd7, 64'hA000_0000_80F0_0000, 12, "R7 pinned purge");
    write_entry(1, 2, 24'd3, 64'h0, 12, "R2 pinned again");
    run_cmd(1, 24'd0, 64'h0, 31, "R7 unsupported pinned purge");
    run_cmd(0, 24'd7, 64'h0000_0000_8000_0000, 12, "R3 purge after unpin");
    write_entry(0, 10, 24'd2, 64'h0, 12, "R2 for flush");
    write_entry(1, 0, 24'd2, 64'h0, 12, "R2 pin for flush");
    run_cmd(2, 24'd0, 64'h0, 12, "R8 flush");
    run_cmd(3, 24'd2, 64'h0, 12, "R9 op 11 ignored");

    // R2: write ignored while a command is presented
    @(negedge clk);
    wr_en = 1'b1; wr_pin = 1'b0; wr_idx = 4'd11; wr_rid = 24'd1; wr_va = '0; wr_size = 5'd12;
    cmd_valid = 1'b1; cmd_op = 2'b11;
    @(negedge clk);
    wr_en = 1'b0; cmd_valid = 1'b0;
    check_state("R2 write blocked by command");
    run_cmd(1, 24'd2, 64'h0, 12, "R7 clear pins");

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int r = $urandom_range(0, 9);
      logic [RID_W-1:0] rid = RID_W'($urandom_range(0, 2));
      logic [63:0] va = {$urandom, $urandom};
      va[60:30] = '0;
      if (r <= 3)      write_entry(0, $urandom_range(0, 15), rid, va, $urandom_range(12, 24), "R2 random write");
      else if (r == 4) write_entry(1, $urandom_range(0, 15), rid, va, $urandom_range(12, 20), "R2 random pin");
      else if (r <= 7) run_cmd(0, rid, va, $urandom_range(10, 30), "R3 random purge");
      else if (r == 8) run_cmd(1, rid, va, $urandom_range(14, 30), "R7 random pin purge");
      else             run_cmd($urandom_range(2, 3), rid, va, 12, "R9 random flush/none");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule